// File: doc/BRIEF.md
# Routed Interrupt Controller with Per-Source Trigger Modes

This block collects interrupt lines from a parameterised number of sources (32 by default) and turns them into two request outputs and one wake output. Each source line first passes through a synchronizer. A per-source trigger mode then decides whether the source is ignored, caught on a rising edge, caught on a falling edge, caught on either edge, or followed as an active-high or active-low level. Edges are held in separate rising and falling capture latches until software clears them.

A source that is pending and unmasked drives the request output that its routing bit selects. A pending source with its wake enable set drives the wake output, whatever its mask. Software reaches every control register over a simple synchronous bus. Each register has a set address, a clear address and a read address. Writing a 1 bit at the set address sets that bit, writing a 1 bit at the clear address clears it, and a 0 bit changes nothing. Two further read addresses return the pending, unmasked sources that drive each request output.

Top module: `irq_router`

## Requirements
- R1: After reset the three mode planes, the mask, the wake enables, both capture latches and the scratch register read 0. The routing and source-select registers read all ones. All three outputs are low.
- R2: For the mode planes, source select, routing, wake and mask registers, a 1 bit written to the set address sets that bit and a 1 bit written to the clear address clears it. Zero bits leave the register unchanged. The capture latches have no set address, so writes to offset 1 of a latch slot change nothing. Addresses are `slot*4 + op`, where op 0 is read, op 1 is set and op 2 is clear. The slots are: mode bit 0 = 0, mode bit 1 = 1, mode bit 2 = 2, source select = 3, routing = 4, wake = 5, mask = 6, rising latch = 7, falling latch = 8, pending for request 0 = 9, pending for request 1 = 10, scratch = 11.
- R3: In mode {b2,b1,b0} = 001 a rising edge sets the source's rising latch and the source stays pending until that latch is cleared. A falling edge is not captured.
- R4: In mode 010 a falling edge sets the falling latch and makes the source pending. A rising edge sets neither latch.
- R5: In mode 011 each edge sets its own latch. The source stays pending until both latches are cleared.
- R6: Mode 101 makes the source pending while its synchronized input is high. Mode 110 makes it pending while the input is low. Neither level mode sets a latch.
- R7: In mode 000 the source never becomes pending and never sets a latch, even when its mask and wake bits are set.
- R8: A pending source drives a request output only while its mask bit is 1. Clearing the mask does not clear a captured edge.
- R9: A source with routing bit 1 drives request output 0. A source with routing bit 0 drives request output 1.
- R10: The pending-readback slots 9 and 10 return, bit by bit, the sources that are pending, unmasked and routed to request 0 and to request 1.
- R11: The wake output is high when any pending source has its wake enable set, independent of the mask.
- R12: Any write to the scratch slot stores the word and reads it back unchanged, with no effect on any output.
- R13: A level change on an input reaches the pending logic two clock edges after it is applied, and not after only one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | N_SRC | Asynchronous source lines |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | N_SRC | Write data |
| bus_rdata | output | N_SRC | Read data, combinational from bus_addr |
| irq_req0 | output | 1 | Request output 0 |
| irq_req1 | output | 1 | Request output 1 |
| irq_wake | output | 1 | Wake output |

## Verification
The bench targets an either-edge source that has been only half acknowledged. A design that cleared pending on the first latch clear would drop the request while the falling edge is still unserved. It also checks that a captured edge survives a mask clear. A design that cleared latches through the mask would lose that interrupt when the mask is set again. Routing is checked with the inverted sense, where a routing bit of 1 selects request 0. Swapping the outputs shows up both on the pins and in the two pending readbacks. Finally, it counts synchronizer latency edge by edge and sends edges of the wrong polarity to each edge mode. A missing stage, or a latch enabled by the wrong mode bit, shows up as a request one cycle early or a capture that should not happen.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
// Package: address slots and operations shared by the controller and its parts.
package intc_pkg;
    localparam int SLOT_CFG0  = 0;
    localparam int SLOT_CFG1  = 1;
    localparam int SLOT_CFG2  = 2;
    localparam int SLOT_SRC   = 3;
    localparam int SLOT_ROUTE = 4;
    localparam int SLOT_WAKE  = 5;
    localparam int SLOT_MASK  = 6;
    localparam int SLOT_RISE  = 7;
    localparam int SLOT_FALL  = 8;
    localparam int SLOT_PND0  = 9;
    localparam int SLOT_PND1  = 10;
    localparam int SLOT_SCR   = 11;
    localparam int NUM_CTRL   = 7;   // set/clear registers in slots 0..6

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } bus_op_e;

    // Reset value of a control slot: source select and routing start at all ones.
    function automatic logic ctrl_reset_bit(input int slot);
        return (slot == SLOT_SRC) || (slot == SLOT_ROUTE);
    endfunction
endpackage

// File: rtl/intc_sync.sv
`timescale 1ns/1ps
// intc_sync: multi-stage synchronizer for the source lines, plus a copy of the
// synchronized value one clock older for edge detection.
// Assumes STAGES >= 1; inputs may change at any time relative to clk.
module intc_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] sync_o,
    output logic [N-1:0] prev_o
);
    logic [STAGES-1:0][N-1:0] stg_q;
    logic [N-1:0]             prev_q;

    // Shift the lines through the synchronizer chain and keep last cycle's value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q  <= '0;
            prev_q <= '0;
        end else begin
            stg_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
            prev_q <= stg_q[STAGES-1];
        end
    end

    assign sync_o = stg_q[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/intc_setclr_reg.sv
`timescale 1ns/1ps
// intc_setclr_reg: one register word written only through separate set and
// clear strobes; ones in wdata select the bits affected.
// Assumes set_we and clr_we are never high together (distinct addresses).
module intc_setclr_reg #(
    parameter int   W      = 32,
    parameter logic RST_BIT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Apply set or clear bit masks; reset loads the configured value.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= {W{RST_BIT}};
        else if (set_we)  q <= q | wdata;
        else if (clr_we)  q <= q & ~wdata;
    end

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((q & $past(wdata)) == $past(wdata)));
    // R2
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((q & $past(wdata)) == '0));
endmodule

// File: rtl/intc_edge_latch.sv
`timescale 1ns/1ps
// intc_edge_latch: per-source rising and falling capture latches.
// A latch bit sets on an enabled edge and clears only on a write of 1 to its
// clear strobe; a new edge in the same cycle as its clear wins.
module intc_edge_latch #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise_ev,
    input  logic [N-1:0] fall_ev,
    input  logic [N-1:0] rise_en,
    input  logic [N-1:0] fall_en,
    input  logic         rise_clr_we,
    input  logic         fall_clr_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] rise_q,
    output logic [N-1:0] fall_q
);
    logic [N-1:0] rise_clr, fall_clr, rise_cap, fall_cap;

    // Form the clear masks and the enabled capture events.
    always_comb begin
        rise_clr = rise_clr_we ? wdata : '0;
        fall_clr = fall_clr_we ? wdata : '0;
        rise_cap = rise_ev & rise_en;
        fall_cap = fall_ev & fall_en;
    end

    // Update both latch arrays.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            rise_q <= (rise_q & ~rise_clr) | rise_cap;
            fall_q <= (fall_q & ~fall_clr) | fall_cap;
        end
    end

    // R3
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_q & ~$past(rise_q) & ~$past(rise_ev & rise_en)) == '0));
    // R4
    fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fall_q & ~$past(fall_q) & ~$past(fall_ev & fall_en)) == '0));
    // R5
    rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(rise_q) & ~$past(rise_clr)) & ~rise_q) == '0));
    // R5
    fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(fall_q) & ~$past(fall_clr)) & ~fall_q) == '0));
endmodule

// File: rtl/intc_trigger.sv
`timescale 1ns/1ps
// intc_trigger: decodes each source's 3-bit mode {b2,b1,b0} into latch enables
// and a pending flag. 000 off, 001 rise, 010 fall, 011 both edges,
// 101 high level, 110 low level; 100 and 111 are treated as off.
module intc_trigger #(
    parameter int N = 32
) (
    input  logic [N-1:0] mode0,
    input  logic [N-1:0] mode1,
    input  logic [N-1:0] mode2,
    input  logic [N-1:0] level,
    input  logic [N-1:0] rise_q,
    input  logic [N-1:0] fall_q,
    output logic [N-1:0] rise_en,
    output logic [N-1:0] fall_en,
    output logic [N-1:0] pend
);
    // Per-source mode decode.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            rise_en[i] = !mode2[i] && mode0[i];
            fall_en[i] = !mode2[i] && mode1[i];
            if (mode2[i])
                pend[i] = (mode0[i] && !mode1[i] && level[i]) ||
                          (mode1[i] && !mode0[i] && !level[i]);
            else
                pend[i] = (mode0[i] && rise_q[i]) || (mode1[i] && fall_q[i]);
        end
    end
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
// irq_router: top of the interrupt controller. Synchronizes the source lines,
// catches edges, decodes trigger modes, gates by mask and routes each source to
// one of two requests; wake follows pending AND wake enable.
// Assumes bus_addr is stable while bus_rdata is sampled; reads are combinational.
module irq_router #(
    parameter int N_SRC       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [N_SRC-1:0]  bus_rdata,
    output logic              irq_req0,
    output logic              irq_req1,
    output logic              irq_wake
);
    import intc_pkg::*;

    localparam int SLOT_W = ADDR_W - 2;

    logic [SLOT_W-1:0]         slot;
    bus_op_e                   op;
    logic [NUM_CTRL-1:0][N_SRC-1:0] ctrl_q;
    logic [N_SRC-1:0]          lvl, lvl_prev, rise_q, fall_q, rise_en, fall_en;
    logic [N_SRC-1:0]          pend, pnd0, pnd1, scratch_q;

    assign slot = bus_addr[ADDR_W-1:2];
    assign op   = bus_op_e'(bus_addr[1:0]);

    intc_sync #(.N(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(src_in), .sync_o(lvl), .prev_o(lvl_prev)
    );

    // One set/clear register per control slot.
    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
        intc_setclr_reg #(.W(N_SRC), .RST_BIT(ctrl_reset_bit(g))) u_reg (
            .clk(clk), .rst_n(rst_n),
            .set_we(bus_we && (slot == SLOT_W'(g)) && (op == OP_SET)),
            .clr_we(bus_we && (slot == SLOT_W'(g)) && (op == OP_CLEAR)),
            .wdata(bus_wdata), .q(ctrl_q[g])
        );
    end

    intc_edge_latch #(.N(N_SRC)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .rise_ev(lvl & ~lvl_prev), .fall_ev(~lvl & lvl_prev),
        .rise_en(rise_en), .fall_en(fall_en),
        .rise_clr_we(bus_we && (slot == SLOT_W'(SLOT_RISE)) && (op == OP_CLEAR)),
        .fall_clr_we(bus_we && (slot == SLOT_W'(SLOT_FALL)) && (op == OP_CLEAR)),
        .wdata(bus_wdata), .rise_q(rise_q), .fall_q(fall_q)
    );

    intc_trigger #(.N(N_SRC)) u_trig (
        .mode0(ctrl_q[SLOT_CFG0]), .mode1(ctrl_q[SLOT_CFG1]), .mode2(ctrl_q[SLOT_CFG2]),
        .level(lvl), .rise_q(rise_q), .fall_q(fall_q),
        .rise_en(rise_en), .fall_en(fall_en), .pend(pend)
    );

    // Scratch word: plain storage, written through any op of its slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   scratch_q <= '0;
        else if (bus_we && slot == SLOT_W'(SLOT_SCR)) scratch_q <= bus_wdata;
    end

    // Route unmasked pending sources to the request selected by the routing bit.
    always_comb begin
        pnd0     = pend & ctrl_q[SLOT_MASK] & ctrl_q[SLOT_ROUTE];
        pnd1     = pend & ctrl_q[SLOT_MASK] & ~ctrl_q[SLOT_ROUTE];
        irq_req0 = |pnd0;
        irq_req1 = |pnd1;
        irq_wake = |(pend & ctrl_q[SLOT_WAKE]);
    end

    // Read multiplexer over all slots.
    always_comb begin
        bus_rdata = '0;
        if (op == OP_READ) begin
            if (slot < SLOT_W'(NUM_CTRL))           bus_rdata = ctrl_q[slot[2:0]];
            else if (slot == SLOT_W'(SLOT_RISE))    bus_rdata = rise_q;
            else if (slot == SLOT_W'(SLOT_FALL))    bus_rdata = fall_q;
            else if (slot == SLOT_W'(SLOT_PND0))    bus_rdata = pnd0;
            else if (slot == SLOT_W'(SLOT_PND1))    bus_rdata = pnd1;
            else if (slot == SLOT_W'(SLOT_SCR))     bus_rdata = scratch_q;
        end
    end

    // R9
    req0_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req0 |-> ((ctrl_q[SLOT_MASK] & ctrl_q[SLOT_ROUTE]) != '0));
    // R9
    req1_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req1 |-> ((ctrl_q[SLOT_MASK] & ~ctrl_q[SLOT_ROUTE]) != '0));
    // R11
    wake_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wake |-> (ctrl_q[SLOT_WAKE] != '0));
    // R7
    off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~(ctrl_q[SLOT_CFG0] | ctrl_q[SLOT_CFG1])) == '0));
endmodule

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected items, a monitor pops and compares.
module sim_irq_router;
    localparam int N = 32;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_in = '0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic          irq_req0, irq_req1, irq_wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int          addr;   // -1 selects the pins {wake, req1, req0}
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    irq_router u0 (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req0(irq_req0), .irq_req1(irq_req1), .irq_wake(irq_wake)
    );

    function automatic int ad(input int slot, input int op);
        return slot * 4 + op;
    endfunction

    // Monitor: compare queued expectations 1 ns after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() != 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                act = (it.addr < 0) ? {29'd0, irq_wake, irq_req1, irq_req0} : bus_rdata;
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s addr=%0d actual=%h expected=%h", it.req, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input int addr, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input int addr, input logic [31:0] e, input string req);
        @(negedge clk);
        bus_addr = AW'(addr);
        sb.push_back('{addr, e, req});
        @(posedge clk);
    endtask

    task automatic pins(input logic [2:0] e, input string req);
        @(negedge clk);
        sb.push_back('{-1, {29'd0, e}, req});
        @(posedge clk);
    endtask

    task automatic drive(input int bitn, input logic v);
        @(negedge clk);
        src_in[bitn] = v;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(ad(0,0), 32'h0, "R1 mode0");
        rd(ad(4,0), 32'hFFFF_FFFF, "R1 route");
        rd(ad(3,0), 32'hFFFF_FFFF, "R1 source");
        rd(ad(6,0), 32'h0, "R1 mask");
        rd(ad(7,0), 32'h0, "R1 rise");
        rd(ad(11,0), 32'h0, "R1 scratch");
        pins(3'b000, "R1 pins");
        // R2 set/clear semantics
        wr(ad(6,1), 32'hF0);
        wr(ad(6,2), 32'h30);
        wr(ad(6,1), 32'h0);
        rd(ad(6,0), 32'hC0, "R2 mask set/clear");
        wr(ad(6,2), 32'hC0);
        rd(ad(6,0), 32'h0, "R2 mask cleared");
        // R3 rising mode on source 0
        wr(ad(0,1), 32'h1); wr(ad(6,1), 32'h1);
        drive(0, 1'b1);
        pins(3'b001, "R3 rise pending");
        rd(ad(7,0), 32'h1, "R3 rise latch");
        rd(ad(9,0), 32'h1, "R10 pend0");
        rd(ad(10,0), 32'h0, "R10 pend1");
        drive(0, 1'b0);
        rd(ad(8,0), 32'h0, "R3 no fall capture");
        wr(ad(7,2), 32'h1);
        pins(3'b000, "R3 ack");
        // R8 mask gating keeps the edge
        wr(ad(6,2), 32'h1);
        drive(0, 1'b1);
        pins(3'b000, "R8 masked");
        rd(ad(7,0), 32'h1, "R8 edge kept");
        wr(ad(6,1), 32'h1);
        pins(3'b001, "R8 unmasked");
        // R9 routing
        wr(ad(4,2), 32'h1);
        pins(3'b010, "R9 route to req1");
        rd(ad(10,0), 32'h1, "R10 pend1 routed");
        rd(ad(9,0), 32'h0, "R10 pend0 empty");
        wr(ad(7,2), 32'h1); drive(0, 1'b0);
        wr(ad(0,2), 32'h1); wr(ad(6,2), 32'h1); wr(ad(4,1), 32'h1);
        pins(3'b000, "R9 cleanup");
        // R4 falling mode on source 1
        wr(ad(1,1), 32'h2); wr(ad(6,1), 32'h2);
        drive(1, 1'b1);
        pins(3'b000, "R4 rise ignored");
        rd(ad(7,0), 32'h0, "R4 no rise latch");
        drive(1, 1'b0);
        pins(3'b001, "R4 fall pending");
        rd(ad(8,0), 32'h2, "R4 fall latch");
        wr(ad(8,2), 32'h2);
        pins(3'b000, "R4 ack");
        wr(ad(1,2), 32'h2); wr(ad(6,2), 32'h2);
        // R5 either edge on source 2
        wr(ad(0,1), 32'h4); wr(ad(1,1), 32'h4); wr(ad(6,1), 32'h4);
        drive(2, 1'b1);
        rd(ad(7,0), 32'h4, "R5 rise latch");
        drive(2, 1'b0);
        rd(ad(8,0), 32'h4, "R5 fall latch");
        wr(ad(7,2), 32'h4);
        pins(3'b001, "R5 half ack still pending");
        wr(ad(8,2), 32'h4);
        pins(3'b000, "R5 full ack");
        wr(ad(0,2), 32'h4); wr(ad(1,2), 32'h4); wr(ad(6,2), 32'h4);
        // R6 / R13 high level on source 3
        wr(ad(2,1), 32'h8); wr(ad(0,1), 32'h8); wr(ad(6,1), 32'h8);
        pins(3'b000, "R6 high idle");
        @(negedge clk); src_in[3] = 1'b1;
        @(posedge clk);
        pins(3'b000, "R13 one edge not yet");
        pins(3'b001, "R13 two edges pending");
        rd(ad(7,0), 32'h0, "R6 no latch in level mode");
        drive(3, 1'b0);
        pins(3'b000, "R6 high level released");
        // R6 low level on source 4
        wr(ad(2,1), 32'h10); wr(ad(1,1), 32'h10); wr(ad(6,1), 32'h10);
        pins(3'b001, "R6 low level pending");
        drive(4, 1'b1);
        pins(3'b000, "R6 low level released");
        wr(ad(2,2), 32'h10); wr(ad(1,2), 32'h10); wr(ad(6,2), 32'h10);
        // R11 wake with mask clear
        wr(ad(6,2), 32'h8); wr(ad(5,1), 32'h8);
        drive(3, 1'b1);
        pins(3'b100, "R11 wake only");
        rd(ad(5,0), 32'h8, "R11 wake reg");
        drive(3, 1'b0);
        pins(3'b000, "R11 wake released");
        // R12 scratch register
        wr(ad(11,1), 32'hFFFF_FFFF);
        rd(ad(11,0), 32'hFFFF_FFFF, "R12 scratch readback");
        pins(3'b000, "R12 no output effect");
        drive(3, 1'b1);
        pins(3'b100, "R12 behaviour unchanged");
        drive(3, 1'b0);
        // R7 disabled source 5
        wr(ad(6,1), 32'h20); wr(ad(5,1), 32'h20);
        drive(5, 1'b1);
        pins(3'b000, "R7 off after rise");
        drive(5, 1'b0);
        pins(3'b000, "R7 off after fall");
        rd(ad(7,0), 32'h0, "R7 no rise latch");
        rd(ad(8,0), 32'h0, "R7 no fall latch");
        // R2 latches have no set address
        wr(ad(7,1), 32'h20);
        rd(ad(7,0), 32'h0, "R2 latch set ignored");
        @(negedge clk); #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule